// File: doc/BRIEF.md
# Split-Bus Requester Deferral Tracker

This block sits on the requesting side of a pipelined split-transaction system bus. It accepts one request at a time through a ready/valid handshake. In the second clock of the request phase it puts the transaction's defer-permission bit and its 8-bit tag onto the bus. It then waits for the snoop result and turns that result into one of four outcomes, which it reports on a single-cycle result strobe:

- the transaction completes in order;
- the transaction must be issued again;
- the transaction is parked as deferred;
- a locked sequence must start over.

While a transaction is parked, the block raises a stall. The stall holds back order-dependent and deferrable requests, and a freeze output holds the snoop state steady. Both stay up until a deferred reply carrying the parked tag is seen. A reply that carries any other tag leaves the block unchanged. Bus-side signals are active-low and are inverted inside the block.

Top module: `defer_tracker`

## Requirements
- R1: After reset, req_ready is 1, stall and freeze are 0, res_valid and reply_done are 0, and bus_den_n and bus_tag_n are all ones.
- R2: A request accepted at a clock edge produces exactly one cycle with ph2 = 1 after that edge. In that cycle bus_den_n = ~req_deferrable and bus_tag_n = ~req_tag. Outside that cycle, bus_den_n and bus_tag_n are all ones.
- R3: A snoop result with snp_defer_n = 1 gives res_valid for one cycle after the sampling edge, with res_code = 0 (in-order).
- R4: A snoop result with both snp_defer_n = 0 and snp_hitm_n = 0 on an unlocked request gives res_code = 0.
- R5: For defer without modified-hit on an unlocked request, no result appears until the response. A response with rsp_kind = 2'b01 then gives res_code = 1 (reissue).
- R6: For a deferred transaction, a response with rsp_kind = 2'b10 gives res_code = 2 (deferred), and raises stall and freeze.
- R7: While stall is 1, req_ready is 0 for any request with req_ordered or req_deferrable set. A request with neither bit set still sees req_ready = 1.
- R8: A deferred reply (rep_valid) whose ~rep_tag_n equals the parked tag clears stall and freeze after that edge, and pulses reply_done for one cycle.
- R9: A deferred reply whose tag differs from the parked tag leaves stall at 1 and reply_done at 0.
- R10: A locked request whose snoop shows defer gives res_code = 3 (restart) whatever snp_hitm_n is, and does not raise stall.
- R11: After defer without modified-hit, a response with rsp_kind = 2'b00 gives res_code = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_tag | input | TAG_W | Identifier of the request |
| req_deferrable | input | 1 | Request may be deferred |
| req_locked | input | 1 | Request opens a locked sequence |
| req_ordered | input | 1 | Request depends on ordering |
| ph2 | output | 1 | Second request clock on the bus |
| bus_den_n | output | 1 | Defer permission, active-low |
| bus_tag_n | output | TAG_W | Identifier on the bus, active-low |
| snp_valid | input | 1 | Snoop result present |
| snp_defer_n | input | 1 | Defer indication, active-low |
| snp_hitm_n | input | 1 | Modified-hit indication, active-low |
| rsp_valid | input | 1 | Response present |
| rsp_kind | input | 2 | 00 in-order, 01 retry, 10 deferred, 11 in-order |
| rep_valid | input | 1 | Deferred reply first request clock |
| rep_tag_n | input | TAG_W | Reply identifier, active-low |
| res_valid | output | 1 | Result strobe |
| res_code | output | 2 | 0 in-order, 1 reissue, 2 deferred, 3 restart |
| stall | output | 1 | Deferred transaction outstanding |
| freeze | output | 1 | Snoop state transitions frozen |
| reply_done | output | 1 | Matching reply consumed |

## Verification
The assertions assume that the surrounding bus offers a snoop result only while a transaction waits for one. They also assume a response arrives only after a deferral, and a defer indication only on deferrable or locked requests. The stimulus stays within these limits: it runs every transaction through accept, snoop and, where needed, response in a fixed order, and it sends replies only while a transaction is parked or while the block is otherwise idle. Each result is checked against an expected-outcome queue, and the stall and handshake conditions are checked directly at the ports.

// File: rtl/defer_tracker.sv
module defer_tracker #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_deferrable,
  input  logic             req_locked,
  input  logic             req_ordered,
  output logic             ph2,
  output logic             bus_den_n,
  output logic [TAG_W-1:0] bus_tag_n,
  input  logic             snp_valid,
  input  logic             snp_defer_n,
  input  logic             snp_hitm_n,
  input  logic             rsp_valid,
  input  logic [1:0]       rsp_kind,
  input  logic             rep_valid,
  input  logic [TAG_W-1:0] rep_tag_n,
  output logic             res_valid,
  output logic [1:0]       res_code,
  output logic             stall,
  output logic             freeze,
  output logic             reply_done
);
  localparam logic [1:0] RES_INORDER = 2'd0;
  localparam logic [1:0] RES_REISSUE = 2'd1;
  localparam logic [1:0] RES_DEFER   = 2'd2;
  localparam logic [1:0] RES_RESTART = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_PH2, S_SNOOP, S_RESP} state_t;
  state_t state;

  logic [TAG_W-1:0] tag_q, park_tag;
  logic den_q, lock_q, parked;

  wire defer  = ~snp_defer_n;
  wire hitm   = ~snp_hitm_n;
  wire accept = req_valid && req_ready;
  wire rep_hit = parked && rep_valid && (~rep_tag_n == park_tag);

  assign req_ready = (state == S_IDLE) && !(parked && (req_ordered || req_deferrable));
  assign ph2       = (state == S_PH2);
  assign bus_den_n = ph2 ? ~den_q : 1'b1;
  assign bus_tag_n = ph2 ? ~tag_q : '1;
  assign stall     = parked;
  assign freeze    = parked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      tag_q      <= '0;
      den_q      <= 1'b0;
      lock_q     <= 1'b0;
      parked     <= 1'b0;
      park_tag   <= '0;
      res_valid  <= 1'b0;
      res_code   <= RES_INORDER;
      reply_done <= 1'b0;
    end else begin
      res_valid  <= 1'b0;
      reply_done <= 1'b0;
      if (rep_hit) begin
        parked     <= 1'b0;
        reply_done <= 1'b1;
      end
      case (state)
        S_IDLE: if (accept) begin
          tag_q  <= req_tag;
          den_q  <= req_deferrable;
          lock_q <= req_locked;
          state  <= S_PH2;
        end
        S_PH2: state <= S_SNOOP;
        S_SNOOP: if (snp_valid) begin
          if (lock_q && defer) begin
            res_valid <= 1'b1;
            res_code  <= RES_RESTART;
            state     <= S_IDLE;
          end else if (!defer || hitm) begin
            res_valid <= 1'b1;
            res_code  <= RES_INORDER;
            state     <= S_IDLE;
          end else begin
            state <= S_RESP;
          end
        end
        S_RESP: if (rsp_valid) begin
          res_valid <= 1'b1;
          state     <= S_IDLE;
          case (rsp_kind)
            2'b01: res_code <= RES_REISSUE;
            2'b10: begin
              res_code <= RES_DEFER;
              parked   <= 1'b1;
              park_tag <= tag_q;
            end
            default: res_code <= RES_INORDER;
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module defer_tracker_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [TAG_W-1:0] req_tag,
  input logic             req_deferrable,
  input logic             req_ordered,
  input logic             ph2,
  input logic             bus_den_n,
  input logic [TAG_W-1:0] bus_tag_n,
  input logic             res_valid,
  input logic [1:0]       res_code,
  input logic             stall,
  input logic             freeze,
  input logic             reply_done
);
  p_ph2_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ph2 && bus_tag_n == ~$past(req_tag)
                                   && bus_den_n == !$past(req_deferrable)));
  p_ph2_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ph2 |=> !ph2);
  p_stall_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && (req_ordered || req_deferrable)) |-> !req_ready);
  p_stall_from_defer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> (res_valid && res_code == 2'd2 && freeze));
  p_reply_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reply_done |-> (!stall && $past(stall)));
endmodule

bind defer_tracker defer_tracker_chk #(.TAG_W(TAG_W)) u_chk (.*);

// File: tb/defer_tracker_test.sv
module defer_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int TAG_W = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_deferrable = 0, req_locked = 0, req_ordered = 0;
  logic [TAG_W-1:0] req_tag = '0;
  logic snp_valid = 0, snp_defer_n = 1, snp_hitm_n = 1;
  logic rsp_valid = 0;
  logic [1:0] rsp_kind = 0;
  logic rep_valid = 0;
  logic [TAG_W-1:0] rep_tag_n = '1;
  logic req_ready, ph2, bus_den_n, res_valid, stall, freeze, reply_done;
  logic [TAG_W-1:0] bus_tag_n;
  logic [1:0] res_code;

  int checks = 0, errors = 0;
  logic [1:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  defer_tracker #(.TAG_W(TAG_W)) uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && res_valid) begin
    if (expq.size() == 0) check(0, "R3 unexpected result", res_code, -1);
    else begin
      logic [1:0] e;
      e = expq.pop_front();
      check(res_code == e, "R3/R4/R5/R6/R10/R11 result code", res_code, e);
    end
  end

  // kind < 0: no response phase expected
  task automatic txn(input logic [7:0] tag, input bit den, input bit lock,
                     input bit dfr, input bit hm, input int kind, input logic [1:0] exp);
    @(negedge clk);
    req_tag = tag; req_deferrable = den; req_locked = lock; req_ordered = 1; req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    check(ph2 && bus_tag_n == ~tag && bus_den_n == !den, "R2 phase-two packet", bus_tag_n, ~tag);
    @(negedge clk);
    check(!ph2 && bus_tag_n == '1 && bus_den_n, "R2 idle bus", bus_tag_n, 8'hff);
    snp_valid = 1; snp_defer_n = !dfr; snp_hitm_n = !hm;
    if (kind < 0) expq.push_back(exp);
    @(negedge clk);
    snp_valid = 0; snp_defer_n = 1; snp_hitm_n = 1;
    if (kind >= 0) begin
      check(!res_valid, "R5 no result before response", res_valid, 0);
      rsp_valid = 1; rsp_kind = kind[1:0];
      expq.push_back(exp);
      @(negedge clk);
      rsp_valid = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !stall && !freeze && !res_valid && !reply_done && bus_tag_n == '1 && bus_den_n,
          "R1 reset state", {req_ready, stall, res_valid}, 3'b100);
    txn(8'h11, 1, 0, 0, 0, -1, 2'd0);   // R3
    txn(8'h22, 1, 0, 1, 1, -1, 2'd0);   // R4
    txn(8'h33, 1, 0, 1, 0, 1, 2'd1);    // R5
    txn(8'h44, 1, 0, 1, 0, 0, 2'd0);    // R11
    txn(8'h55, 1, 1, 1, 1, -1, 2'd3);   // R10 with hit
    check(!stall, "R10 no stall", stall, 0);
    txn(8'h66, 0, 1, 1, 0, -1, 2'd3);   // R10 without hit
    txn(8'hA5, 1, 0, 1, 0, 2, 2'd2);    // R6
    check(stall && freeze, "R6 stall and freeze", {stall, freeze}, 3);
    req_ordered = 1; req_deferrable = 0;
    #1 check(!req_ready, "R7 ordered blocked", req_ready, 0);
    req_ordered = 0; req_deferrable = 1;
    #1 check(!req_ready, "R7 deferrable blocked", req_ready, 0);
    req_ordered = 0; req_deferrable = 0;
    #1 check(req_ready, "R7 unordered allowed", req_ready, 1);
    @(negedge clk);
    rep_valid = 1; rep_tag_n = ~8'hA4;
    @(negedge clk);
    rep_valid = 0; rep_tag_n = '1;
    check(stall && !reply_done, "R9 mismatched reply ignored", {stall, reply_done}, 2);
    @(negedge clk);
    check(stall, "R9 still parked", stall, 1);
    rep_valid = 1; rep_tag_n = ~8'hA5;
    @(negedge clk);
    rep_valid = 0; rep_tag_n = '1;
    check(!stall && !freeze && reply_done, "R8 matching reply", {stall, reply_done}, 1);
    @(negedge clk);
    check(!reply_done, "R8 single pulse", reply_done, 0);
    req_ordered = 1;
    #1 check(req_ready, "R8 ordered accepted again", req_ready, 1);
    txn(8'h77, 1, 0, 0, 1, -1, 2'd0);   // R3 again after release
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R3 all results seen", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R1 watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule